// File: doc/BRIEF.md
# Programmable Modulus Integer Clock Divider

This block divides an input clock by any whole number N from 8 to 511. N is read from a 9-bit parallel word. The divided output does not use a plain half-and-half split. The time it stays high follows a fixed rule per octave of N, and ratios below 16 use their own short pattern.

The modulus word is sampled once per output period, on the same input edge that starts the period and raises the output. The block stores that sample for the rest of the period, so the word may change at any time without cutting an output pulse short. A modulator can therefore drive the word with a new ratio every output period, as in fractional-N synthesis. Typical sequences alternate 8/9 or 16/17, or follow a noise-shaped pattern.

Top module: `modulus_divider`

## Requirements
- R1: The modulus N is the unsigned binary value of `div_sel`, with bit 8 as the most significant bit. For every N from 8 to 511, each output period lasts exactly N input clock cycles.
- R2: For N from 16 to 511, the output stays high for half of the largest power of two that does not exceed N. This gives 8, 16, 32, 64 and 128 input cycles for the octaves starting at 16, 32, 64, 128 and 256.
- R3: For N from 8 to 11, the output stays high for N-4 input cycles.
- R4: For N from 12 to 15, the output stays high for N-8 input cycles.
- R5: A `div_sel` value from 0 to 7 is treated as 8: the period is 8 cycles and the high time is 4 cycles.
- R6: `div_sel` is sampled on the input edge where the output rises, and that value sets the period that edge begins. A different ratio may be used in every successive period, for example 8/9 or 16/17 alternation.
- R7: Changes to `div_sel` after the rising edge of a period have no effect on that period. Only the value present at the next rising edge is used.
- R8: While `rst_sync` is sampled high, the output is low on the next edge and stays low.
- R9: On the first input edge with `rst_sync` low, the output rises and the first period begins.
- R10: When N is a power of two from 8 to 256, the high time is exactly half of the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_sync | input | 1 | Synchronous reset, active high |
| div_sel | input | 9 | Modulus word, unsigned, bit 8 is the MSB |
| div_out | output | 1 | Divided clock output |

## Verification
A sweep through every ratio from 8 to 511, one period each, separates the three high-time rules. It also shows up any off-by-one at an octave boundary, such as 15 to 16 or 255 to 256. Values 0 to 7 show whether the clamp applies. Strict 8/9 and 16/17 alternation, together with a random ratio sequence, shows whether a new word lands on exactly the next period. A word changed in the middle of a period, and then changed again before the next rising edge, separates sampling at the period start from sampling at any other time. A reset applied mid-period shows that the output falls at once and that the first period starts on the first edge after release.

// File: rtl/modulus_divider.sv
module modulus_divider #(
  parameter int CTRL_W = 9
) (
  input  logic              clk_in,
  input  logic              rst_sync,
  input  logic [CTRL_W-1:0] div_sel,
  output logic              div_out
);

  localparam logic [CTRL_W-1:0] ONE     = CTRL_W'(1);
  localparam logic [CTRL_W-1:0] FOUR    = CTRL_W'(4);
  localparam logic [CTRL_W-1:0] EIGHT   = CTRL_W'(8);
  localparam logic [CTRL_W-1:0] TWELVE  = CTRL_W'(12);
  localparam logic [CTRL_W-1:0] SIXTEEN = CTRL_W'(16);

  function automatic logic [CTRL_W-1:0] high_of(input logic [CTRL_W-1:0] n);
    logic [CTRL_W-1:0] r;
    r = '0;
    if (n < TWELVE) begin
      r = n - FOUR;
    end else if (n < SIXTEEN) begin
      r = n - EIGHT;
    end else begin
      for (int i = 4; i < CTRL_W; i++) begin
        if (n[i]) begin
          r = '0;
          r[i-1] = 1'b1;
        end
      end
    end
    return r;
  endfunction

  logic [CTRL_W-1:0] cnt, n_lat, hi_lat, n_new, hi_new;
  logic              at_start;

  assign at_start = (cnt == '0);
  assign n_new    = (div_sel < EIGHT) ? EIGHT : div_sel;
  assign hi_new   = high_of(n_new);

  always_ff @(posedge clk_in) begin
    if (rst_sync) begin
      cnt     <= '0;
      n_lat   <= EIGHT;
      hi_lat  <= FOUR;
      div_out <= 1'b0;
    end else if (at_start) begin
      n_lat   <= n_new;
      hi_lat  <= hi_new;
      div_out <= 1'b1;
      cnt     <= ONE;
    end else begin
      div_out <= (cnt < hi_lat);
      cnt     <= (cnt == n_lat - ONE) ? '0 : cnt + ONE;
    end
  end

  // R6
  rise_at_start_chk: assert property (@(posedge clk_in) disable iff (rst_sync)
    $rose(div_out) |-> ($past(cnt) == '0));

  // R7
  hold_mid_period_chk: assert property (@(posedge clk_in) disable iff (rst_sync)
    (cnt != '0) |=> $stable(n_lat));

  // R1
  count_in_range_chk: assert property (@(posedge clk_in) disable iff (rst_sync)
    (cnt < n_lat) && (n_lat >= EIGHT));

  // R2
  duty_bound_chk: assert property (@(posedge clk_in) disable iff (rst_sync)
    (n_lat >= SIXTEEN) |-> ((hi_lat <= (n_lat >> 1)) && (hi_lat > (n_lat >> 2))));

  // R8
  reset_low_chk: assert property (@(posedge clk_in)
    rst_sync |=> !div_out);

endmodule

// File: tb/modulus_divider_bench.sv
module modulus_divider_bench;
  logic       clk_in = 1'b0;
  logic       rst_sync;
  logic [8:0] div_sel;
  logic       div_out;

  int checks = 0;
  int errors = 0;
  int cur    = 8;
  bit done   = 0;

  always #2 clk_in = ~clk_in;

  modulus_divider u_modulus_divider (
    .clk_in(clk_in), .rst_sync(rst_sync), .div_sel(div_sel), .div_out(div_out)
  );

  function automatic int eff_n(input int v);
    return (v < 8) ? 8 : v;
  endfunction

  function automatic int exp_hi(input int v);
    int n, p;
    n = eff_n(v);
    if (n < 12) return n - 4;
    if (n < 16) return n - 8;
    p = 1;
    while (p * 2 <= n) p = p * 2;
    return p / 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Entry: just after a negedge where div_out is in the first high cycle of a period.
  task automatic period(input int nxt, input int mid_at, input int mid_sel, input string hreq);
    int hi, per, n;
    hi = 0; per = 0;
    div_sel = 9'(nxt);
    while (div_out == 1'b1 && per < 1100) begin
      if (per == mid_at) div_sel = 9'(mid_sel);
      hi++; per++;
      @(negedge clk_in);
    end
    while (div_out == 1'b0 && per < 1100) begin
      if (per == mid_at) div_sel = 9'(mid_sel);
      per++;
      @(negedge clk_in);
    end
    n = eff_n(cur);
    check(per == n, "R1 period", per, n);
    check(hi == exp_hi(cur), hreq, hi, exp_hi(cur));
    if ((n & (n - 1)) == 0 && n <= 256) check(hi * 2 == per, "R10 half duty", hi * 2, per);
    cur = (mid_at >= 0) ? mid_sel : nxt;
  endtask

  task automatic reset_test(input int first);
    rst_sync = 1'b1;
    div_sel  = 9'(first);
    @(negedge clk_in);
    for (int i = 0; i < 4; i++) begin
      check(div_out == 1'b0, "R8 reset low", div_out, 0);
      @(negedge clk_in);
    end
    rst_sync = 1'b0;
    cur = first;
    @(negedge clk_in);
    check(div_out == 1'b1, "R9 first edge rise", div_out, 1);
  endtask

  task automatic sweep_test;
    for (int n = 8; n <= 511; n++) begin
      string req;
      req = (n < 12) ? "R3 high" : (n < 16) ? "R4 high" : "R2 high";
      period((n == 511) ? 0 : n + 1, -1, 0, req);
    end
  endtask

  task automatic clamp_test;
    for (int v = 0; v < 8; v++) period(v + 1, -1, 0, "R5 clamp high");
  endtask

  task automatic alternate_test(input int a, input int b);
    for (int i = 0; i < 10; i++) period((i % 2 == 0) ? b : a, -1, 0, "R6 alternate high");
  endtask

  task automatic midchange_test;
    period(9, 3, 300, "R7 mid-period high");
    period(20, 2, 17, "R7 after mid-change high");
    period(8, -1, 0, "R7 second mid-change high");
  endtask

  task automatic random_test;
    for (int i = 0; i < 60; i++) period(int'($urandom_range(8, 80)), -1, 0, "R6 random high");
  endtask

  initial begin
    rst_sync = 1'b1;
    div_sel  = 9'd0;
    repeat (2) @(negedge clk_in);
    reset_test(8);
    sweep_test();
    clamp_test();
    alternate_test(8, 9);
    alternate_test(16, 17);
    midchange_test();
    random_test();
    repeat (5) @(negedge clk_in);
    reset_test(13);
    period(64, -1, 0, "R4 after reset high");
    period(8, -1, 0, "R2 after reset high");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_in);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule